// File: doc/BRIEF.md
# Pre-Trigger Capture Buffer with Delayed Streaming

This block records a steady stream of ADC samples into a circular store whose working depth is chosen at run time. Recording never stops, so the store always holds the most recent samples. When a trigger is accepted, the block counts down a programmable delay and then streams the buffered history out on a valid/ready interface. The stream begins with the oldest sample still held, so the moments that led up to the trigger are part of the output.

While streaming runs, a trigger-out line and a data-active line are both high. Streaming ends when a programmed number of samples has been handed over, or when the stream enable drops. Capture carries on during streaming. If the consumer stalls long enough that a new sample would overwrite one that has not been read, the oldest unread sample is dropped and a sticky overflow flag is set. That flag clears on the next accepted trigger.

Top module: `pretrig_capture`

## Requirements
- R1: Every cycle with `sampleValid` high stores `sampleData`, whatever the trigger state, and this includes cycles in which streaming is running.
- R2: Only the latest `cfgSize` samples are kept. `cfgSize` lies between 1 and the physical depth (16 by default). Older samples are overwritten in circular order.
- R3: The first streamed sample is the oldest one held. After N writes from reset, this is write number max(0, N-`cfgSize`), counting from 0, and the following samples come out in write order.
- R4: `trigOut` rises exactly `cfgDelay`+1 clock edges after the edge at which the trigger was accepted.
- R5: `trigOut` and `dataActive` are high for the whole of streaming and low otherwise. `outValid` is never high while `dataActive` is low.
- R6: A trigger is accepted only when `enable` is high and the block is idle. A `trigIn` pulse during the delay or during streaming changes neither the delay timing nor the end of streaming.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays constant, provided `enable` stays high and no sample arrives.
- R8: A sample that arrives during streaming, when `cfgSize` samples are unread and nothing is being popped, drops the oldest unread sample and sets `overflow`. The flag stays set until the next accepted trigger clears it.
- R9: Streaming stops and `trigOut` falls on the edge after the `cfgCount`-th transfer (`cfgCount` must be at least 1), or on the first edge at which `enable` is low.
- R10: After reset, `outValid`, `trigOut`, `dataActive` and `overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Stream enable: allows triggers and keeps streaming going |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | DATA_W | Sample value |
| trigIn | input | 1 | Trigger event |
| cfgSize | input | ADDR_W+1 | Active ring depth, 1..2^ADDR_W |
| cfgDelay | input | DLY_W | Cycles to wait after the trigger |
| cfgCount | input | CNT_W | Samples to send per trigger, at least 1 |
| outValid | output | 1 | Stream data valid |
| outReady | input | 1 | Stream consumer ready |
| outData | output | DATA_W | Streamed sample |
| trigOut | output | 1 | High from the end of the delay until streaming stops |
| dataActive | output | 1 | High while streaming is in progress |
| overflow | output | 1 | Sticky flag: unread data was overwritten |

## Verification
The assertions assume that `cfgSize`, `cfgDelay` and `cfgCount` stay fixed from the trigger until streaming ends. They also assume that `cfgSize` is within range and `cfgCount` is non-zero. The stall property assumes that neither `enable` nor `sampleValid` changes the buffer while the consumer holds back. The stimulus meets these assumptions as follows. Every configuration is applied under reset before its case runs. Samples are written only before a trigger, except in one deliberate overflow case that toggles a single input at a time. Sweeps cover several ring sizes, fill levels below, at and above the size, and several delay values.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_STREAM
  } ctrl_state_t;

  // Strobes the sequencer hands to the storage side
  typedef struct packed {
    logic armTrig;      // trigger accepted this cycle
    logic startStream;  // delay expired, load read pointer
    logic streaming;    // stream phase in progress
    logic pop;          // output handshake completes this cycle
  } ctrl_strobe_t;
endpackage

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
  import pretrig_pkg::*;
#(
  parameter int DLY_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 trigIn,
  input  logic [DLY_W-1:0]     cfgDelay,
  input  logic [CNT_W-1:0]     cfgCount,
  input  logic                 availNz,
  input  logic                 outReady,
  output ctrl_strobe_t         strobe,
  output logic                 trigOut,
  output logic                 dataActive
);
  ctrl_state_t           state;
  logic [DLY_W-1:0]      dlyCnt;
  logic [CNT_W-1:0]      remaining;

  always_comb begin
    strobe.armTrig     = (state == ST_IDLE) && enable && trigIn;
    strobe.startStream = (state == ST_DELAY) && enable && (dlyCnt == '0);
    strobe.streaming   = (state == ST_STREAM);
    strobe.pop         = (state == ST_STREAM) && availNz && outReady;
  end

  assign trigOut    = (state == ST_STREAM);
  assign dataActive = (state == ST_STREAM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dlyCnt    <= '0;
      remaining <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobe.armTrig) begin
            state  <= ST_DELAY;
            dlyCnt <= cfgDelay;
          end
        end
        ST_DELAY: begin
          if (!enable) begin
            state <= ST_IDLE;
          end else if (dlyCnt == '0) begin
            state     <= ST_STREAM;
            remaining <= cfgCount;
          end else begin
            dlyCnt <= dlyCnt - 1'b1;
          end
        end
        ST_STREAM: begin
          if (!enable) begin
            state <= ST_IDLE;
          end else if (strobe.pop) begin
            remaining <= remaining - 1'b1;
            if (remaining == CNT_W'(1)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pretrig_datapath.sv
module pretrig_datapath
  import pretrig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [ADDR_W:0]   cfgSize,
  input  ctrl_strobe_t      strobe,
  output logic [DATA_W-1:0] outData,
  output logic              availNz,
  output logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SZ_W  = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [SZ_W-1:0]   fill, avail;
  logic              full, ringFull;

  function automatic logic [ADDR_W-1:0] stepPtr(input logic [ADDR_W-1:0] p,
                                                input logic [SZ_W-1:0] sz);
    return ((SZ_W'(p) + 1'b1) >= sz) ? '0 : p + 1'b1;
  endfunction

  assign wrNext   = stepPtr(wrPtr, cfgSize);
  assign rdNext   = stepPtr(rdPtr, cfgSize);
  assign full     = (fill >= cfgSize);
  assign ringFull = (avail >= cfgSize);
  assign availNz  = (avail != '0);
  assign outData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (sampleValid) mem[wrPtr] <= sampleData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      fill     <= '0;
      avail    <= '0;
      overflow <= 1'b0;
    end else begin
      if (sampleValid) begin
        wrPtr <= wrNext;
        if (!full) fill <= fill + 1'b1;
      end
      if (strobe.armTrig) overflow <= 1'b0;

      if (strobe.startStream) begin
        if (full) begin
          rdPtr <= sampleValid ? wrNext : wrPtr;
          avail <= cfgSize;
        end else begin
          rdPtr <= '0;
          avail <= fill + SZ_W'(sampleValid);
        end
      end else if (strobe.streaming) begin
        if (sampleValid && !strobe.pop && ringFull) begin
          overflow <= 1'b1;
          rdPtr    <= rdNext;
        end else begin
          if (strobe.pop) rdPtr <= rdNext;
          if (sampleValid && !strobe.pop)      avail <= avail + 1'b1;
          else if (!sampleValid && strobe.pop) avail <= avail - 1'b1;
        end
      end else begin
        avail <= '0;
      end
    end
  end
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import pretrig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int DLY_W  = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              trigIn,
  input  logic [ADDR_W:0]   cfgSize,
  input  logic [DLY_W-1:0]  cfgDelay,
  input  logic [CNT_W-1:0]  cfgCount,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              trigOut,
  output logic              dataActive,
  output logic              overflow
);
  ctrl_strobe_t strobe;
  logic         availNz;

  pretrig_ctrl #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .trigIn(trigIn),
    .cfgDelay(cfgDelay), .cfgCount(cfgCount), .availNz(availNz),
    .outReady(outReady), .strobe(strobe), .trigOut(trigOut),
    .dataActive(dataActive)
  );

  pretrig_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleData(sampleData), .cfgSize(cfgSize), .strobe(strobe),
    .outData(outData), .availNz(availNz), .overflow(overflow)
  );

  assign outValid = strobe.streaming && availNz;
endmodule

// File: rtl/pretrig_capture_chk.sv
module pretrig_capture_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              sampleValid,
  input logic              trigIn,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              trigOut,
  input logic              dataActive,
  input logic              overflow
);
  AST_VALID_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> dataActive); // R5

  AST_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    trigOut == dataActive); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && enable && !sampleValid)
      |=> (outValid && $stable(outData))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !trigIn) |=> overflow); // R8

  AST_ENABLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !trigOut); // R9

  AST_NO_RESTART_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && enable && !(outValid && outReady)) |=> trigOut); // R6
endmodule

bind pretrig_capture pretrig_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
  .trigIn(trigIn), .outValid(outValid), .outReady(outReady),
  .outData(outData), .trigOut(trigOut), .dataActive(dataActive),
  .overflow(overflow)
);

// File: tb/pretrig_capture_test.sv
`timescale 1ns/1ps
module pretrig_capture_test;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int DLY_W  = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic trigIn = 1'b0;
  logic [ADDR_W:0] cfgSize = 5'd4;
  logic [DLY_W-1:0] cfgDelay = '0;
  logic [CNT_W-1:0] cfgCount = 16'd1;
  logic outReady = 1'b0;
  logic outValid, trigOut, dataActive, overflow;
  logic [DATA_W-1:0] outData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pretrig_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
    .sampleData(sampleData), .trigIn(trigIn), .cfgSize(cfgSize),
    .cfgDelay(cfgDelay), .cfgCount(cfgCount), .outValid(outValid),
    .outReady(outReady), .outData(outData), .trigOut(trigOut),
    .dataActive(dataActive), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; trigIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeSamples(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      sampleValid = 1'b1; sampleData = DATA_W'(base + i);
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  task automatic pulseTrig();
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  // Returns negedges from the accepting edge until trigOut is seen high
  task automatic waitTrigOut(output int k, input bit retrig);
    k = 0;
    while (!trigOut && k < 1000) begin
      if (retrig && k == 1) trigIn = 1'b1;
      @(negedge clk);
      trigIn = 1'b0;
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int sizes [4] = '{3, 5, 8, 16};
    int delays [3] = '{0, 2, 5};
    int caseId = 0;
    // R10 reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(!outValid && !trigOut && !dataActive && !overflow, "R10 reset outputs",
        int'({outValid, trigOut, dataActive, overflow}), 0);
    rstN = 1'b1;

    foreach (sizes[si]) begin
      for (int fi = 0; fi < 3; fi++) begin
        foreach (delays[di]) begin
          int sz = sizes[si];
          int n = (fi == 0) ? 2 : (fi == 1) ? sz : sz + 3;
          int cnt = (n < sz) ? n : sz;
          int first = (n > sz) ? n - sz : 0;
          int base = 256 * (caseId + 1);
          int k;
          int got;
          caseId++;
          cfgSize = (ADDR_W+1)'(sz);
          cfgDelay = DLY_W'(delays[di]);
          cfgCount = CNT_W'(cnt);
          enable = 1'b1;
          outReady = 1'b1;
          doReset();
          writeSamples(n, base);
          chk(!trigOut, "R5 idle before trigger", int'(trigOut), 0);
          pulseTrig();
          waitTrigOut(k, delays[di] >= 2);
          chk(k == delays[di] + 1, "R4/R6 delay to trigOut", k, delays[di] + 1);
          chk(dataActive, "R5 dataActive in stream", int'(dataActive), 1);
          got = 0;
          for (int g = 0; g < 4 * cnt + 8 && got < cnt; g++) begin
            if (outValid) begin
              chk(int'(outData) == base + first + got,
                  (got == 0) ? "R3 oldest first" : "R1/R2 stream order",
                  int'(outData), base + first + got);
              if (got == 0) trigIn = 1'b1;
              got++;
            end
            @(negedge clk);
            trigIn = 1'b0;
          end
          chk(got == cnt, "R2 sample count", got, cnt);
          chk(!trigOut && !dataActive && !outValid, "R9 stop after count",
              int'({trigOut, dataActive, outValid}), 0);
          repeat (3) @(negedge clk);
          chk(!trigOut, "R6 trigger in stream ignored", int'(trigOut), 0);
        end
      end
    end

    // Overflow, stall and enable cases
    cfgSize = 5'd4; cfgDelay = '0; cfgCount = 16'd10;
    enable = 1'b1; outReady = 1'b0;
    doReset();
    writeSamples(4, 16'hA1);
    pulseTrig();
    begin
      int k;
      waitTrigOut(k, 1'b0);
      chk(k == 1, "R4 zero delay", k, 1);
    end
    chk(outValid && outData == 16'hA1, "R3 oldest with stall", int'(outData), 16'hA1);
    chk(!overflow, "R8 no overflow yet", int'(overflow), 0);
    repeat (3) @(negedge clk);
    chk(outValid && outData == 16'hA1, "R7 stall holds data", int'(outData), 16'hA1);
    writeSamples(1, 16'hA5);
    chk(overflow, "R8 overflow set", int'(overflow), 1);
    chk(outData == 16'hA2, "R8 oldest dropped", int'(outData), 16'hA2);
    outReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(outValid && int'(outData) == 16'hA2 + i, "R1 capture during stream",
          int'(outData), 16'hA2 + i);
      @(negedge clk);
    end
    chk(!outValid && trigOut, "R5 active while drained", int'({outValid, trigOut}), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!trigOut && !dataActive, "R9 enable low stops", int'(trigOut), 0);
    chk(overflow, "R8 overflow sticky", int'(overflow), 1);
    pulseTrig();
    chk(overflow, "R6 trigger ignored while disabled", int'(overflow), 1);
    enable = 1'b1;
    pulseTrig();
    chk(!overflow, "R8 cleared by trigger", int'(overflow), 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule